// File: doc/BRIEF.md
# EEPROM Page-Load Write Controller

This block is a synthesizable behavioural model of the write path of a byte-wide parallel EEPROM. A host drives three active-low strobes (chip select, output enable, write enable), a 15-bit address and an 8-bit data bus. A write starts a burst: the first byte fixes a 128-byte page, and later bytes to that same page go into a page buffer. Each new write strobe must begin before a load-window timer runs out. When the window expires with no strobe active, the buffered bytes are copied into the storage array and a programming timer starts.

While programming is under way, every read returns a status byte in place of array data. Bit 7 is the inverse of bit 7 of the last byte loaded. Bit 6 flips after each read. Once programming finishes, reads return the stored data again. Both timer lengths are parameters counted in clock cycles. The storage array is a small register memory indexed by the low address bits. The strobe inputs are sampled on the clock, so every pulse the host gives must span at least one clock edge.

Top module: `eeprom_page_writer`

## Requirements
- R1: During and directly after reset, `busy`, `pageErr` and `dataDrive` are all 0 and every array byte reads as 0.
- R2: `dataDrive` is 1 exactly when `ceN` and `oeN` are both 0. Whenever `dataDrive` is 0, `dataOut` is 8'h00.
- R3: A write strobe exists only while `ceN` and `weN` are 0 and `oeN` is 1. With `oeN` held 0, or with `weN` held 1, nothing is loaded and no programming starts.
- R4: The address is taken at the clock edge where the write strobe first appears, that is, at the later of the chip-select and write-enable falls. The data is taken at the edge where the strobe first disappears, that is, at the earlier of the two rises.
- R5: Programming begins LOAD_WIN clock edges after the edge that saw the most recent accepted write strobe begin. It begins only at an edge where no write strobe is present. `busy` is 1 from then on.
- R6: Every byte loaded during a burst reaches the array at offset address[6:0] of the burst's page, and a full 128-byte page can be loaded in one burst.
- R7: A byte whose address[14:7] differs from the first byte of its burst is dropped. It also sets `pageErr`, which stays 1 until reset. The other bytes of the burst are still written.
- R8: While `busy` is 1, a read returns bit 7 equal to the inverse of bit 7 of the last loaded byte. Bit 6 is inverted after each completed read, and bits 5:0 read as 0.
- R9: `busy` stays 1 for exactly PROG_CYC clock cycles. Afterwards, reads return the stored data.
- R10: Write strobes that begin while `busy` is 1 are ignored.
- R11: When the same address is loaded twice in one burst, the later value is the one stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data or status byte |
| dataDrive | output | 1 | High when the data bus would be driven |
| busy | output | 1 | Programming cycle in progress |
| pageErr | output | 1 | Sticky flag for a dropped cross-page byte |

## Verification
Reads are combinational. The bench therefore samples `dataOut` one clock after it applies a read and keeps both strobes low until it has sampled. A loaded byte enters the page buffer on the edge that sees its write strobe end, so the bench holds the data through that edge. The programming start is checked by counting edges from the edge that first saw the strobe to the first negative half-cycle in which `busy` reads 1; that count must equal LOAD_WIN. The programming length is checked by counting the negative half-cycles in which `busy` is 1; that count must equal PROG_CYC. The status toggle is predicted one read at a time, and the prediction is inverted only after a read that ended while `busy` was 1.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;
  localparam int PAGE_BYTES = 128;
  localparam int PAGE_OFF_W = $clog2(PAGE_BYTES);

  // strobes from control to datapath
  typedef struct packed {
    logic capAddr;     // latch address of an accepted load
    logic firstLoad;   // first load of a burst: also latch page
    logic commitByte;  // put data into page buffer
    logic startProg;   // copy page buffer into array
    logic readEnd;     // a read finished while programming
  } pwStrobe_t;
endpackage

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import eeprom_pw_pkg::*;
#(
  parameter int LOAD_WIN = 64,
  parameter int PROG_CYC = 256
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      ceN,
  input  logic      oeN,
  input  logic      weN,
  input  logic      pageMatch,
  output pwStrobe_t strobe,
  output logic      busy,
  output logic      pageErr
);
  localparam int WIN_W  = $clog2(LOAD_WIN + 1);
  localparam int PROG_W = $clog2(PROG_CYC + 1);
  localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(LOAD_WIN - 1);
  localparam logic [PROG_W-1:0] PROG_LAST = PROG_W'(PROG_CYC - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PROG} pwState_e;

  pwState_e state;
  logic [WIN_W-1:0]  winCnt;
  logic [PROG_W-1:0] progCnt;
  logic prevWa, prevRa, loadOk;
  logic wrActive, rdActive, waRise, waFall;
  logic acceptLoad, rejectLoad, fireProg;

  assign wrActive = !ceN && !weN && oeN;
  assign rdActive = !ceN && !oeN;
  assign waRise   = wrActive && !prevWa;
  assign waFall   = !wrActive && prevWa;
  assign busy     = (state == ST_PROG);

  always_comb begin
    acceptLoad = 1'b0;
    rejectLoad = 1'b0;
    fireProg   = 1'b0;
    strobe     = '0;
    case (state)
      ST_IDLE: begin
        if (waRise) begin
          acceptLoad       = 1'b1;
          strobe.firstLoad = 1'b1;
        end
      end
      ST_LOAD: begin
        if (waRise) begin
          acceptLoad = pageMatch;
          rejectLoad = !pageMatch;
        end
        if (waFall && loadOk) strobe.commitByte = 1'b1;
        if (!wrActive && !waFall && winCnt == WIN_LAST) fireProg = 1'b1;
      end
      default: ;
    endcase
    strobe.capAddr   = acceptLoad;
    strobe.startProg = fireProg;
    strobe.readEnd   = busy && prevRa && !rdActive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      winCnt  <= '0;
      progCnt <= '0;
      prevWa  <= 1'b0;
      prevRa  <= 1'b0;
      loadOk  <= 1'b0;
      pageErr <= 1'b0;
    end else begin
      prevWa <= wrActive;
      prevRa <= rdActive;
      if (rejectLoad) pageErr <= 1'b1;
      if (waRise)      loadOk <= acceptLoad;
      else if (waFall) loadOk <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (acceptLoad) begin
            state  <= ST_LOAD;
            winCnt <= '0;
          end
        end
        ST_LOAD: begin
          if (fireProg) begin
            state   <= ST_PROG;
            progCnt <= '0;
          end else if (acceptLoad) begin
            winCnt <= '0;
          end else if (winCnt != WIN_LAST) begin
            winCnt <= winCnt + 1'b1;
          end
        end
        default: begin
          if (progCnt == PROG_LAST) state <= ST_IDLE;
          else progCnt <= progCnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/pw_datapath.sv
module pw_datapath
  import eeprom_pw_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int MEM_BYTES = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  pwStrobe_t         strobe,
  input  logic              busy,
  output logic              pageMatch,
  output logic [7:0]        dataOut,
  output logic              dataDrive
);
  localparam int MEM_AW = $clog2(MEM_BYTES);
  localparam int PAGE_W = ADDR_W - PAGE_OFF_W;

  logic [PAGE_W-1:0]     pageReg;
  logic [PAGE_OFF_W-1:0] offReg;
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageValid;
  logic [7:0]            arrayMem [MEM_BYTES];
  logic [7:0]            lastData;
  logic                  togBit;
  logic [MEM_AW-1:0]     rdIdx;

  function automatic logic [MEM_AW-1:0] memIndex(input logic [PAGE_W-1:0] pg,
                                                 input logic [PAGE_OFF_W-1:0] off);
    logic [ADDR_W-1:0] full;
    full = {pg, off};
    return full[MEM_AW-1:0];
  endfunction

  assign pageMatch = (addr[ADDR_W-1:PAGE_OFF_W] == pageReg);
  assign rdIdx     = addr[MEM_AW-1:0];
  assign dataDrive = !ceN && !oeN;

  always_comb begin
    if (!dataDrive)  dataOut = 8'h00;
    else if (busy)   dataOut = {~lastData[7], togBit, 6'b0};
    else             dataOut = arrayMem[rdIdx];
  end

  // address, page and status registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg  <= '0;
      offReg   <= '0;
      lastData <= '0;
      togBit   <= 1'b0;
    end else begin
      if (strobe.capAddr) begin
        offReg <= addr[PAGE_OFF_W-1:0];
        if (strobe.firstLoad) pageReg <= addr[ADDR_W-1:PAGE_OFF_W];
      end
      if (strobe.commitByte) lastData <= dataIn;
      if (strobe.readEnd)    togBit   <= ~togBit;
    end
  end

  // page buffer contents
  always_ff @(posedge clk) begin
    if (strobe.commitByte) pageBuf[offReg] <= dataIn;
  end

  // valid mask and array transfer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageValid <= '0;
      for (int m = 0; m < MEM_BYTES; m++) arrayMem[m] <= 8'h00;
    end else begin
      if (strobe.startProg) begin
        for (int i = 0; i < PAGE_BYTES; i++) begin
          if (pageValid[i]) arrayMem[memIndex(pageReg, PAGE_OFF_W'(i))] <= pageBuf[i];
        end
        pageValid <= '0;
      end else if (strobe.commitByte) begin
        pageValid[offReg] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eeprom_pw_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int MEM_BYTES = 512,
  parameter int LOAD_WIN  = 64,
  parameter int PROG_CYC  = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataDrive,
  output logic              busy,
  output logic              pageErr
);
  pwStrobe_t strobe;
  logic      pageMatch;

  pw_ctrl #(.LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .pageMatch(pageMatch), .strobe(strobe), .busy(busy), .pageErr(pageErr)
  );

  pw_datapath #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .addr(addr),
    .dataIn(dataIn), .strobe(strobe), .busy(busy), .pageMatch(pageMatch),
    .dataOut(dataOut), .dataDrive(dataDrive)
  );
endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
  parameter int PROG_CYC = 256
) (
  input logic       clk,
  input logic       rstN,
  input logic       ceN,
  input logic       oeN,
  input logic       weN,
  input logic [7:0] dataOut,
  input logic       dataDrive,
  input logic       busy,
  input logic       pageErr
);
  int   busyRun;
  logic lastTog, haveTog;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyRun <= 0;
      lastTog <= 1'b0;
      haveTog <= 1'b0;
    end else begin
      busyRun <= busy ? busyRun + 1 : 0;
      if (!busy) haveTog <= 1'b0;
      else if (dataDrive) begin
        lastTog <= dataOut[6];
        haveTog <= 1'b1;
      end
    end
  end

  p_quiet_bus_r2: assert property (@(posedge clk) disable iff (!rstN)
    !dataDrive |-> dataOut == 8'h00);

  p_start_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(ceN || weN || !oeN));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    pageErr |=> pageErr);

  p_toggle_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dataDrive) && busy && haveTog) |-> dataOut[6] != lastTog);

  p_prog_len_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyRun == PROG_CYC);
endmodule

bind eeprom_page_writer pw_checker #(.PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
  .dataOut(dataOut), .dataDrive(dataDrive), .busy(busy), .pageErr(pageErr)
);

// File: tb/sim_eeprom_page_writer.sv
module sim_eeprom_page_writer;
  localparam int ADDR_W    = 15;
  localparam int MEM_BYTES = 512;
  localparam int LOAD_WIN  = 16;
  localparam int PROG_CYC  = 40;

  logic clk = 1'b0;
  logic rstN, ceN, oeN, weN;
  logic [ADDR_W-1:0] addr;
  logic [7:0] dataIn, dataOut;
  logic dataDrive, busy, pageErr;

  always #10 clk = ~clk;

  eeprom_page_writer #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES),
                       .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .dataDrive(dataDrive),
    .busy(busy), .pageErr(pageErr)
  );

  int checks = 0, errors = 0;
  int cyc = 0, startCyc = 0;
  int runLen = 0, lastRun = 0, riseCyc = 0;
  logic seenBusy = 1'b0;
  logic expTog = 1'b0;
  logic [7:0] model [MEM_BYTES];

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (busy) begin
      if (!seenBusy) riseCyc = cyc;
      runLen++;
    end else if (seenBusy) begin
      lastRun = runLen;
      runLen  = 0;
    end
    seenBusy = busy;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeByte(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; dataIn = d; oeN = 1'b1; ceN = 1'b0; weN = 1'b0;
    startCyc = cyc + 1;
    @(negedge clk);
    @(negedge clk);
    weN = 1'b1;
    @(negedge clk);
    ceN = 1'b1;
  endtask

  task automatic readByte(input logic [ADDR_W-1:0] a, output logic [7:0] d, output logic drv);
    @(negedge clk);
    addr = a; weN = 1'b1; ceN = 1'b0; oeN = 1'b0;
    @(negedge clk);
    #1;
    d = dataOut; drv = dataDrive;
    if (busy) expTog = ~expTog;
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic waitBusy();
    for (int n = 0; n < 2000 && !busy; n++) @(negedge clk);
    #2;
  endtask

  task automatic waitIdle();
    for (int n = 0; n < 2000 && busy; n++) @(negedge clk);
    @(negedge clk);
    #2;
  endtask

  task automatic statusRead(input string tag, input logic [7:0] last);
    logic [7:0] d; logic drv; logic tg;
    tg = expTog;
    readByte(15'h0010, d, drv);
    check(d[7] == ~last[7], {tag, " R8 bit7"}, d[7], ~last[7]);
    check(d[6] == tg, {tag, " R8 bit6"}, d[6], tg);
    check(d[5:0] == 6'd0, {tag, " R8 low bits"}, d[5:0], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d; logic drv; logic [7:0] v;
    for (int m = 0; m < MEM_BYTES; m++) model[m] = 8'h00;
    rstN = 1'b0; ceN = 1'b1; oeN = 1'b1; weN = 1'b1; addr = '0; dataIn = '0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    check(pageErr == 1'b0, "R1 pageErr in reset", pageErr, 0);
    check(dataDrive == 1'b0, "R1 drive in reset", dataDrive, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: all strobe combinations for the read path
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      ceN = c[0]; oeN = c[1]; weN = 1'b1;
      #2;
      check(dataDrive == (c == 0), "R2 drive", dataDrive, c == 0);
      if (c != 0) check(dataOut == 8'h00, "R2 idle value", dataOut, 0);
    end
    @(negedge clk); ceN = 1'b1; oeN = 1'b1;

    // R3: write attempts blocked by OE low and by WE high
    @(negedge clk); addr = 15'h0005; dataIn = 8'hAA; oeN = 1'b0; ceN = 1'b0; weN = 1'b0;
    repeat (3) @(negedge clk); weN = 1'b1; ceN = 1'b1; oeN = 1'b1;
    @(negedge clk); ceN = 1'b0; weN = 1'b1;
    repeat (3) @(negedge clk); ceN = 1'b1;
    repeat (LOAD_WIN + 6) @(negedge clk);
    #2;
    check(busy == 1'b0 && riseCyc == 0, "R3 no programming", busy, 0);
    readByte(15'h0005, d, drv);
    check(d == 8'h00, "R3 byte unchanged", d, 0);

    // R5, R8, R9, R10: single byte
    writeByte(15'h0010, 8'h3C); model[16'h0010] = 8'h3C;
    waitBusy();
    check(riseCyc - startCyc == LOAD_WIN, "R5 start delay", riseCyc - startCyc, LOAD_WIN);
    statusRead("single", 8'h3C);
    statusRead("single", 8'h3C);
    statusRead("single", 8'h3C);
    writeByte(15'h0011, 8'h77);
    waitIdle();
    check(lastRun == PROG_CYC, "R9 busy length", lastRun, PROG_CYC);
    readByte(15'h0010, d, drv);
    check(d == 8'h3C, "R9 true data", d, 8'h3C);
    readByte(15'h0011, d, drv);
    check(d == 8'h00, "R10 write during busy", d, 0);

    // R6, R11: full page burst plus a rewrite
    for (int i = 0; i < 128; i++) begin
      v = 8'((i * 37 + 11) & 8'hFF);
      writeByte(15'(16'h0080 + i), v);
      model[16'h0080 + i] = v;
    end
    writeByte(15'h0085, 8'hE1); model[16'h0085] = 8'hE1;
    waitBusy();
    statusRead("page", 8'hE1);
    waitIdle();
    check(lastRun == PROG_CYC, "R9 busy length page", lastRun, PROG_CYC);

    // R7: cross-page byte in a burst
    writeByte(15'h0100, 8'h5A); model[16'h0100] = 8'h5A;
    writeByte(15'h0180, 8'h99);
    check(pageErr == 1'b1, "R7 flag set", pageErr, 1);
    writeByte(15'h0101, 8'hA5); model[16'h0101] = 8'hA5;
    waitBusy();
    waitIdle();

    // R4: address at strobe start, data at strobe end (WE then CE controlled)
    @(negedge clk); addr = 15'h0020; dataIn = 8'h11; oeN = 1'b1; ceN = 1'b0; weN = 1'b0;
    @(negedge clk); addr = 15'h0021; dataIn = 8'h22;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); ceN = 1'b1;
    model[16'h0020] = 8'h22;
    @(negedge clk); addr = 15'h07FF; weN = 1'b0; ceN = 1'b1;
    @(negedge clk); addr = 15'h0030; dataIn = 8'h44; ceN = 1'b0;
    @(negedge clk); ceN = 1'b1;
    @(negedge clk); weN = 1'b1;
    model[16'h0030] = 8'h44;
    waitBusy();
    waitIdle();
    check(pageErr == 1'b1, "R7 flag sticky", pageErr, 1);

    // R6 sweep of the whole array against the bench model (covers R4, R7, R11)
    for (int a = 0; a < MEM_BYTES; a++) begin
      readByte(15'(a), d, drv);
      check(drv == 1'b1 && d == model[a], $sformatf("R6 sweep addr %0h", a), d, model[a]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule